// File: doc/BRIEF.md
# Bidirectional Bus Turnaround Controller

This block steers data between two m-bit bus segments, called left and right, through two banks of tristate drivers. One bank copies the left segment onto the right one. The other copies the right segment onto the left one. A requested direction comes in as a level. The block holds a registered direction, a global driver enable and the two bank enables derived from them. It also models what each segment reads: the opposite side's data while the bank facing it drives, and all ones from a pull-up while no bank drives it.

Whenever the requested direction differs from the held direction, the controller runs a break-before-make turnaround:
- It drops the global enable first.
- It waits a guard interval, then switches the direction while every driver is off.
- It waits again, then raises the enable.
- It waits a final settling interval before it accepts transfers again.

Each of these three phases lasts `GUARD` clocks. A busy flag and a transfer-ready flag let the neighbouring logic stall its data handshake during the turnaround. The request is compared only while the controller sits in its steady driving state, so a request that flips again mid-turnaround is acted on afterwards.

Top module: `bus_turn_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, the block is in the driving state with the direction at `RST_DIR` (default 1), the enable at 1, busy at 0 and ready at 1.
- R2: With direction 1 and the enable at 1, right_bus equals left_src. With direction 0 and the enable at 1, left_bus equals right_src.
- R3: A segment whose facing bank is off reads all ones (every bit 1). Both segments read all ones while the enable is 0.
- R4: When the driving state samples a request that differs from the held direction, the enable is 0 and busy is 1 in the cycle after that clock edge, and the direction is still the old value.
- R5: The direction changes only while the enable is 0 and was already 0 in the previous cycle. It flips `GUARD` cycles after the enable fell.
- R6: The enable returns to 1 `GUARD` cycles after the direction flipped.
- R7: Busy stays high for exactly 3*`GUARD` cycles per turnaround. Ready is the inverse of busy, and ready high implies the enable is 1.
- R8: The left-to-right and right-to-left bank enables are never both 1 in any cycle.
- R9: Changes of the request during a turnaround do not alter that turnaround. The request is compared again on return to the driving state, so a request that toggled back starts a second turnaround on the next cycle.
- R10: While the request equals the held direction, the direction and the enable stay unchanged and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_req | input | 1 | Requested direction: 1 left-to-right, 0 right-to-left |
| left_src | input | WIDTH | Data offered by the left endpoint |
| right_src | input | WIDTH | Data offered by the right endpoint |
| dir_out | output | 1 | Registered direction |
| drv_en | output | 1 | Registered global driver enable |
| l2r_en | output | 1 | Left-to-right bank enable |
| r2l_en | output | 1 | Right-to-left bank enable |
| busy | output | 1 | Turnaround in progress |
| xfer_ready | output | 1 | Data handshake may proceed |
| left_bus | output | WIDTH | Value read on the left segment |
| right_bus | output | WIDTH | Value read on the right segment |

## Verification
The bench builds the block with `WIDTH`=4 and `GUARD`=3. The narrow width lets every pair of left and right data values be swept in both directions, covering all 256 combinations per direction against the pull-up. A guard of 3 makes each phase boundary inside a turnaround distinct, so the bench can check the enable fall, the direction flip, the enable rise and the busy release at separate cycles. It also drives a request that toggles back mid-turnaround to show that this request is held off until the driving state and then starts a second turnaround.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;
  typedef enum logic [1:0] {
    ST_DRIVE    = 2'd0,
    ST_DISABLE  = 2'd1,
    ST_SWITCH   = 2'd2,
    ST_REENABLE = 2'd3
  } turn_state_t;
endpackage

// File: rtl/bus_turn_guard.sv
// Phase length counter: done pulses on the last cycle of a GUARD-long phase.
module bus_turn_guard #(
  parameter int GUARD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic done
);
  localparam int CW = (GUARD > 1) ? $clog2(GUARD) : 1;
  localparam logic [CW-1:0] LAST = CW'(GUARD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

  // R6: phase counter never runs past the guard length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
endmodule

// File: rtl/bus_turn_fsm.sv
// Break-before-make sequencer: disable, switch, re-enable.
module bus_turn_fsm
  import bus_turn_pkg::*;
#(
  parameter bit RST_DIR = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dir_req,
  input  logic        phase_done,
  output logic        guard_clear,
  output logic        dir_q,
  output logic        en_q,
  output logic        busy_q
);
  turn_state_t state;

  assign guard_clear = (state == ST_DRIVE) || phase_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_DRIVE;
      dir_q  <= RST_DIR;
      en_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (state)
        ST_DRIVE: begin
          if (dir_req != dir_q) begin
            state  <= ST_DISABLE;
            en_q   <= 1'b0;
            busy_q <= 1'b1;
          end
        end
        ST_DISABLE: begin
          if (phase_done) begin
            state <= ST_SWITCH;
            dir_q <= ~dir_q;
          end
        end
        ST_SWITCH: begin
          if (phase_done) begin
            state <= ST_REENABLE;
            en_q  <= 1'b1;
          end
        end
        ST_REENABLE: begin
          if (phase_done) begin
            state  <= ST_DRIVE;
            busy_q <= 1'b0;
          end
        end
        default: state <= ST_DRIVE;
      endcase
    end
  end

  // R4: a differing request drops the enable and raises busy, direction held
  p_en_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE && dir_req != dir_q) |=> (!en_q && busy_q && $stable(dir_q)));
  // R5: direction moves only with drivers already off for a cycle
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_q) |-> (!en_q && !$past(en_q)));
  // R9: direction moves only when leaving the disable phase
  p_dir_phase_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_q) |-> ($past(state) == ST_DISABLE));
  // R7: drivers are off only inside a turnaround
  p_busy_cover_r7: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> busy_q);
endmodule

// File: rtl/bus_turn_bank.sv
// Tristate driver bank onto a pulled-up segment, modelled per bit.
module bus_turn_bank #(
  parameter int WIDTH = 8
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] seg
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign seg[i] = oe ? src[i] : 1'b1;
  end
endmodule

// File: rtl/bus_turn_ctrl.sv
module bus_turn_ctrl #(
  parameter int WIDTH   = 8,
  parameter int GUARD   = 2,
  parameter bit RST_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_req,
  input  logic [WIDTH-1:0] left_src,
  input  logic [WIDTH-1:0] right_src,
  output logic             dir_out,
  output logic             drv_en,
  output logic             l2r_en,
  output logic             r2l_en,
  output logic             busy,
  output logic             xfer_ready,
  output logic [WIDTH-1:0] left_bus,
  output logic [WIDTH-1:0] right_bus
);
  logic guard_clear;
  logic phase_done;

  bus_turn_guard #(.GUARD(GUARD)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .clear (guard_clear),
    .done  (phase_done)
  );

  bus_turn_fsm #(.RST_DIR(RST_DIR)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .dir_req     (dir_req),
    .phase_done  (phase_done),
    .guard_clear (guard_clear),
    .dir_q       (dir_out),
    .en_q        (drv_en),
    .busy_q      (busy)
  );

  assign l2r_en     = drv_en & dir_out;
  assign r2l_en     = drv_en & ~dir_out;
  assign xfer_ready = ~busy;

  bus_turn_bank #(.WIDTH(WIDTH)) u_bank_l2r (
    .oe  (l2r_en),
    .src (left_src),
    .seg (right_bus)
  );

  bus_turn_bank #(.WIDTH(WIDTH)) u_bank_r2l (
    .oe  (r2l_en),
    .src (right_src),
    .seg (left_bus)
  );

  // R8: the two banks never drive together
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(l2r_en && r2l_en));
  // R3: an undriven segment reads the pull-up value
  p_float_r3: assert property (@(posedge clk) disable iff (rst)
    (!drv_en) |-> (left_bus == '1 && right_bus == '1));
  // R7: handshake may proceed only with drivers on
  p_ready_en_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_ready |-> drv_en);
endmodule

// File: tb/bus_turn_ctrl_bench.sv
module bus_turn_ctrl_bench;
  localparam int W = 4;
  localparam int G = 3;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst;
  logic dir_req;
  logic [W-1:0] left_src, right_src;
  logic dir_out, drv_en, l2r_en, r2l_en, busy, xfer_ready;
  logic [W-1:0] left_bus, right_bus;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  always #4 clk = ~clk;

  bus_turn_ctrl #(.WIDTH(W), .GUARD(G), .RST_DIR(1'b1)) u_bus_turn_ctrl (
    .clk(clk), .rst(rst), .dir_req(dir_req),
    .left_src(left_src), .right_src(right_src),
    .dir_out(dir_out), .drv_en(drv_en), .l2r_en(l2r_en), .r2l_en(r2l_en),
    .busy(busy), .xfer_ready(xfer_ready),
    .left_bus(left_bus), .right_bus(right_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && l2r_en && r2l_en) overlaps++;

  task automatic sweep(input bit d);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        left_src  = W'(a);
        right_src = W'(b);
        #1;
        if (d) begin
          chk(right_bus == W'(a), "R2 right_bus", right_bus, a);
          chk(left_bus == ONES, "R3 left_bus pull-up", left_bus, ONES);
        end else begin
          chk(left_bus == W'(b), "R2 left_bus", left_bus, b);
          chk(right_bus == ONES, "R3 right_bus pull-up", right_bus, ONES);
        end
      end
    end
  endtask

  // Turnaround from old_d to ~old_d; request already driven before edge E0.
  task automatic check_turn(input bit old_d);
    for (int j = 0; j < 3*G + 1; j++) begin
      @(negedge clk);
      chk(drv_en == !(j < 2*G), "R4/R6 enable timing", drv_en, !(j < 2*G));
      chk(dir_out == ((j >= G) ? !old_d : old_d), "R5 direction timing", dir_out, (j >= G) ? !old_d : old_d);
      chk(busy == (j < 3*G), "R7 busy length", busy, j < 3*G);
      chk(xfer_ready == !busy, "R7 ready inverse", xfer_ready, !busy);
      if (j < 2*G) begin
        chk(left_bus == ONES && right_bus == ONES, "R3 both float", {left_bus, right_bus}, {ONES, ONES});
      end
    end
  endtask

  initial begin
    rst = 1'b1; dir_req = 1'b1; left_src = '0; right_src = '0;
    repeat (2) @(negedge clk);
    chk(dir_out == 1'b1, "R1 reset dir", dir_out, 1);
    chk(drv_en == 1'b1, "R1 reset enable", drv_en, 1);
    chk(busy == 1'b0 && xfer_ready == 1'b1, "R1 reset busy/ready", {busy, xfer_ready}, 2'b01);
    rst = 1'b0;

    // R10: stable request keeps state
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(dir_out == 1'b1 && drv_en == 1'b1 && busy == 1'b0, "R10 steady", {dir_out, drv_en, busy}, 3'b110);
    end

    sweep(1'b1);

    // Turnaround 1 -> 0
    @(negedge clk);
    dir_req = 1'b0;
    check_turn(1'b1);
    sweep(1'b0);

    // R9: request toggles back during the turnaround
    @(negedge clk);
    dir_req = 1'b1;
    for (int j = 0; j < 3*G + 1; j++) begin
      @(negedge clk);
      if (j == 0) dir_req = 1'b0;
      if (j == G) chk(dir_out == 1'b1, "R9 turnaround unaltered", dir_out, 1);
      if (j == 3*G - 1) chk(busy == 1'b1, "R9 still busy", busy, 1);
      if (j == 3*G) chk(busy == 1'b0 && dir_out == 1'b1, "R9 back in drive", {busy, dir_out}, 2'b01);
    end
    // Edge after returning to drive samples the toggled-back request
    check_turn(1'b1);
    chk(dir_out == 1'b0 && drv_en == 1'b1, "R9 second turnaround done", {dir_out, drv_en}, 2'b01);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dir_out == 1'b0 && busy == 1'b0, "R10 steady after", {dir_out, busy}, 2'b00);
    end

    chk(overlaps == 0, "R8 bank overlap count", overlaps, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule